// File: doc/BRIEF.md
# Pair-Grouped Simultaneous Sampling Sequencer

This block is the digital control core of a six-channel sampling converter whose channels are grouped in three pairs. Each pair has its own active-high start input. A rising edge on one or more start inputs, seen while the block is idle, puts those pairs into hold. It raises one shared busy flag and times a fixed conversion with a cycle counter that is derived from the system clock frequency. When the count expires, the block loads a 16-bit result for every channel of the started pairs into a six-entry output register, releases the holds and drops busy.

The conversion itself is modelled by a per-channel data input, which is sampled on the completion cycle. The input span for a conversion is chosen either by an external range pin or by a bit in a small control register. The chosen value is frozen when the conversion starts, so a change made while busy only affects the next conversion. Each output entry keeps the range that was used to produce it. Results are fetched through a plain synchronous read port.

Top module: `simsamp_seq`

## Requirements
- R1: Bit 0 of `start_i` governs channels 1 and 2 (read addresses 0 and 1), bit 1 governs channels 3 and 4 (addresses 2 and 3), and bit 2 governs channels 5 and 6 (addresses 4 and 5). `hold_o` bit p is 1 while pair p is held.
- R2: A rising edge on a start input, seen while idle, sets `busy_o` and that pair's `hold_o` bit on the third rising clock edge after the input goes high (two synchronizer stages and one capture register). Neither is set earlier.
- R3: `busy_o` stays high for exactly CONV_CYC clock cycles, where CONV_CYC = (CLK_HZ/1000)*CONV_NS/1000000. This is 375 at the defaults of 125 MHz and 3000 ns.
- R4: Start edges that arrive on several inputs in the same cycle while idle join one conversion. After completion, `last_pairs_o` shows the 3-bit mask of the pairs that were started.
- R5: Rising edges on any start input while `busy_o` is high are ignored. They neither change `hold_o` nor start another conversion after the current one ends, and they are not included in `last_pairs_o`.
- R6: On the cycle `busy_o` falls, `hold_o` returns to 0 and the started channels' results become readable. `rd_data_o` and `rd_range_o` show the entry at `rd_addr_i` one clock after the address is applied.
- R7: Output entries of pairs that were not started keep their previous data and range.
- R8: The range is sampled when a conversion starts. The source is `cfg_range` (written with `cfg_wr_i`) when `range_src_i` is 1, and `range_pin_i` when it is 0. The value 1 means the ±2×Vref span and 0 means the ±4×Vref span. It is stored with each written entry and reported on `last_range_o`. A change made during busy applies only to the next conversion.
- R9: After reset, `busy_o`, `hold_o`, `last_pairs_o` and `last_range_o` are 0, and every entry reads data 0 with range 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 3 | Asynchronous per-pair start requests |
| range_pin_i | input | 1 | External range select |
| range_src_i | input | 1 | 1: use control-register range, 0: use pin |
| cfg_wr_i | input | 1 | Write strobe for the range control bit |
| cfg_range_i | input | 1 | Value written to the range control bit |
| conv_data_i | input | 96 | Modelled conversion result, channel n in bits [16n+15:16n] |
| rd_addr_i | input | 3 | Output-register read address (0 to 5) |
| busy_o | output | 1 | Conversion in progress |
| hold_o | output | 3 | Per-pair hold control |
| last_pairs_o | output | 3 | Pairs converted in the last conversion |
| last_range_o | output | 1 | Range used by the last conversion |
| rd_data_o | output | 16 | Read data |
| rd_range_o | output | 1 | Range stored with the read entry |

## Verification
The embedded properties assume that the timer is loaded only when idle and that a conversion always starts with a non-empty pair mask. The stimulus therefore raises start inputs only when the sequencer is idle, except in the deliberate lockout test. In that test a start pulse lands well inside the busy window and is dropped again long before the window ends. Range and control-register changes are applied just after busy rises, so the capture point is never ambiguous. Every read address stays within the six valid entries.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;
  localparam int NPAIR = 3;
  localparam int NCH   = 2 * NPAIR;
  localparam int AW    = 3;
endpackage

// File: rtl/start_edge.sv
module start_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= async_i[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise_o[g] = s2 & ~s3;
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CYC = 375
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= LAST;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q <= LAST));
  assert_no_reload_R5: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !run_q);
endmodule

// File: rtl/result_bank.sv
module result_bank
  import simsamp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [NPAIR-1:0]  pair_mask_i,
  input  logic              wr_rng_i,
  input  logic [NCH*DW-1:0] data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_rng_o
);
  logic [DW-1:0] mem [NCH];
  logic          rng [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[c] <= '0;
        rng[c] <= 1'b0;
      end else if (wr_en_i && pair_mask_i[c/2]) begin
        mem[c] <= data_i[c*DW +: DW];
        rng[c] <= wr_rng_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      rd_rng_o  <= 1'b0;
    end else if (int'(rd_addr_i) < NCH) begin
      rd_data_o <= mem[rd_addr_i];
      rd_rng_o  <= rng[rd_addr_i];
    end else begin
      rd_data_o <= '0;
      rd_rng_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq
  import simsamp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CLK_HZ  = 125_000_000,
  parameter int CONV_NS = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        start_i,
  input  logic              range_pin_i,
  input  logic              range_src_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_range_i,
  input  logic [6*DW-1:0]   conv_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic              busy_o,
  output logic [2:0]        hold_o,
  output logic [2:0]        last_pairs_o,
  output logic              last_range_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_range_o
);
  localparam int CONV_CYC = (CLK_HZ / 1000) * CONV_NS / 1000000;

  logic [NPAIR-1:0] rise;
  logic             go, done;
  logic             cfg_rng_q, conv_rng_q, eff_rng;

  start_edge #(.W(NPAIR)) u_edge (
    .clk(clk), .rst(rst), .async_i(start_i), .rise_o(rise)
  );

  assign go      = !busy_o && (|rise);
  assign eff_rng = range_src_i ? cfg_rng_q : range_pin_i;

  conv_timer #(.CYC(CONV_CYC)) u_timer (
    .clk(clk), .rst(rst), .load_i(go), .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rng_q    <= 1'b0;
      conv_rng_q   <= 1'b0;
      busy_o       <= 1'b0;
      hold_o       <= '0;
      last_pairs_o <= '0;
      last_range_o <= 1'b0;
    end else begin
      if (cfg_wr_i) cfg_rng_q <= cfg_range_i;
      if (go) begin
        busy_o     <= 1'b1;
        hold_o     <= rise;
        conv_rng_q <= eff_rng;
      end else if (done) begin
        busy_o       <= 1'b0;
        hold_o       <= '0;
        last_pairs_o <= hold_o;
        last_range_o <= conv_rng_q;
      end
    end
  end

  result_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst(rst), .wr_en_i(done), .pair_mask_i(hold_o),
    .wr_rng_i(conv_rng_q), .data_i(conv_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .rd_rng_o(rd_range_o)
  );

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (hold_o != '0));
  assert_hold_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(hold_o));
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (hold_o == '0));
  assert_mask_report_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (last_pairs_o == $past(hold_o)));
endmodule

// File: tb/simsamp_seq_tb.sv
`timescale 1ns/1ps
module simsamp_seq_tb;
  localparam int DW = 16;
  localparam int CYC = 375;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] start_i = '0;
  logic range_pin_i = 1'b0, range_src_i = 1'b0, cfg_wr_i = 1'b0, cfg_range_i = 1'b0;
  logic [6*DW-1:0] conv_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic busy_o, last_range_o, rd_range_o;
  logic [2:0] hold_o, last_pairs_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_mem [6];
  logic          exp_rng [6];
  logic [DW:0]   sbq [$];
  logic rd_req = 1'b0, rd_pend_q = 1'b0;

  always #4 clk = ~clk;

  simsamp_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .range_pin_i(range_pin_i),
    .range_src_i(range_src_i), .cfg_wr_i(cfg_wr_i), .cfg_range_i(cfg_range_i),
    .conv_data_i(conv_data_i), .rd_addr_i(rd_addr_i), .busy_o(busy_o),
    .hold_o(hold_o), .last_pairs_o(last_pairs_o), .last_range_o(last_range_o),
    .rd_data_o(rd_data_o), .rd_range_o(rd_range_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_pend_q <= rd_req;

  always @(negedge clk) begin
    if (rd_pend_q) begin
      logic [DW:0] e;
      e = sbq.pop_front();
      checks++;
      if ({rd_data_o, rd_range_o} !== e) begin
        fails++;
        $display("FAIL R6 R7 R8 readback: actual %0h/%0b expected %0h/%0b",
                 rd_data_o, rd_range_o, e[DW:1], e[0]);
      end
    end
  end

  task automatic readback();
    for (int a = 0; a < 6; a++) begin
      @(negedge clk);
      rd_addr_i = 3'(a);
      sbq.push_back({exp_mem[a], exp_rng[a]});
      rd_req = 1'b1;
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic conv(input logic [2:0] mask, input int seed, input logic exp_r,
                      input logic mid_pin, input logic mid_wr, input logic mid_cfg,
                      input logic [2:0] mid_start);
    int n;
    for (int c = 0; c < 6; c++) conv_data_i[c*DW +: DW] = DW'(seed * 16'h0101 + c * 16'h0011);
    @(negedge clk);
    start_i = mask;
    @(negedge clk);
    chk("R2 busy after one edge", busy_o, 0);
    @(negedge clk);
    chk("R2 busy after two edges", busy_o, 0);
    @(negedge clk);
    chk("R2 busy on third edge", busy_o, 1);
    chk("R1 R2 hold mask", hold_o, mask);
    start_i = mid_start;
    range_pin_i = mid_pin;
    cfg_wr_i = mid_wr;
    cfg_range_i = mid_cfg;
    n = 1;
    forever begin
      @(negedge clk);
      cfg_wr_i = 1'b0;
      if (n == 4) start_i = '0;
      if (!busy_o) break;
      if (hold_o != mask) chk("R5 hold steady", hold_o, mask);
      n++;
    end
    chk("R3 busy length", n, CYC);
    chk("R6 hold released", hold_o, 0);
    chk("R4 R5 last pairs", last_pairs_o, mask);
    chk("R8 last range", last_range_o, exp_r);
    for (int c = 0; c < 6; c++)
      if (mask[c/2]) begin
        exp_mem[c] = conv_data_i[c*DW +: DW];
        exp_rng[c] = exp_r;
      end
    repeat (6) @(negedge clk);
    chk("R5 no late restart", busy_o, 0);
    readback();
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 6; c++) begin exp_mem[c] = '0; exp_rng[c] = 1'b0; end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 busy reset", busy_o, 0);
    chk("R9 hold reset", hold_o, 0);
    chk("R9 last pairs reset", last_pairs_o, 0);
    chk("R9 last range reset", last_range_o, 0);
    readback();
    // pair A only, pin range 0; pin flips and start C pulses during busy (R5, R8)
    conv(3'b001, 1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b100);
    // pairs B and C together pick up pin value 1 (R4, R7, R8)
    conv(3'b110, 2, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000);
    // register source: write 0 first, pin stays 1
    range_src_i = 1'b1;
    @(negedge clk); cfg_wr_i = 1'b1; cfg_range_i = 1'b0;
    @(negedge clk); cfg_wr_i = 1'b0;
    // all pairs; register written to 1 during busy applies next time (R8)
    conv(3'b111, 3, 1'b0, 1'b1, 1'b1, 1'b1, 3'b000);
    conv(3'b001, 4, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule